// File: doc/BRIEF.md
# Power-Good Qualified System Reset Generator

This block drives an active-low system reset from per-rail power-good and power-fail flags and from general-purpose input levels. Two masks choose which rails and which inputs count. Reset is released once every selected condition is good and a programmable delay has elapsed. All time is measured in pulses of a 1 ms tick-enable input.

In level mode, reset drops at once when a selected rail reports a failure or a selected input goes low. In pulse mode, the output stays released while the block waits. After the delay it emits a single low pulse of programmable width. Losing power-good then re-arms it for the next pulse.

A CPU watchdog runs while reset is released. Its first window, the start time, counts from release. Each later window, the period, counts from the most recent kick. A timeout sends the block back through the release delay. A configuration-write strobe forces reset low briefly, after which the conditions are evaluated afresh.

Top module: `pg_reset_gen`

## Requirements
- R1: Reset is released only while every rail selected in `rail_mask` has `rail_pg_on` high and every input selected in `gpi_mask` is high; deselected rails and inputs have no effect on release.
- R2: The release delay is set by the 5-bit `delay_code`. Code 0 means no delay. Code n from 1 to 16 means 2^(n-1) ticks, and codes above 16 behave as 16. After a configuration write with all conditions good, the output rises within delay+1 to delay+3 clock cycles when the tick is high every cycle.
- R3: In level mode (`pulse_mode`=0), reset asserts on the clock edge after a selected rail's `rail_pg_fail` goes high or a selected input goes low. A failure flag on a deselected rail does nothing.
- R4: In pulse mode (`pulse_mode`=1), the output is high while the block waits. After the delay it is low for `pulse_width` ticks (0 is treated as 1), give or take two cycles, and then it is released.
- R5: A watchdog kick is a rising edge on `wdi`. It is resynchronised through two flops. While `wdg_en` is set and reset is released, no timeout occurs before `wdg_start` ticks after release, or before `wdg_period` ticks after the latest kick.
- R6: On a watchdog timeout in level mode, reset asserts and is released again after the programmed delay.
- R7: Reset is asserted after `rst`, and for at least the cycle after every `cfg_write` pulse, even when the release conditions hold.
- R8: If the release conditions fail while the delay is counting, the count restarts from zero and reset stays asserted.
- R9: The delay, pulse and watchdog timers advance only on cycles where `tick_ms` is high.
- R10: In pulse mode, a loss of release conditions after the pulse does not assert reset. It re-arms the block, and the next return of power-good produces another pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | 1 ms timing enable |
| rail_pg_on | input | N_RAILS | Rail above its power-good-on threshold |
| rail_pg_fail | input | N_RAILS | Rail below its power-good-off threshold |
| rail_mask | input | N_RAILS | Rails that take part |
| gpi_in | input | N_GPI | General-purpose input levels |
| gpi_mask | input | N_GPI | Inputs that take part |
| delay_code | input | 5 | Release delay code |
| pulse_mode | input | 1 | 1 = one-shot pulse, 0 = level |
| pulse_width | input | 15 | Pulse width in ticks |
| wdg_en | input | 1 | Watchdog enable |
| wdg_start | input | TIMER_W | Watchdog first window in ticks |
| wdg_period | input | TIMER_W | Watchdog window between kicks |
| wdi | input | 1 | Watchdog kick input (asynchronous) |
| cfg_write | input | 1 | Configuration rewritten strobe |
| sys_rst_n | output | 1 | Active-low system reset, registered |

## Verification
The output is registered from the next-state logic. A failure or a timeout therefore shows on `sys_rst_n` one edge after it is seen. The bench drives inputs on the falling edge and looks one falling edge later. A release after a configuration write lands delay+2 edges after the strobe edge: one edge for the configuration state, one to clear the counter, and delay edges of counting. The bench accepts a one-cycle window around that point. Kicks reach the watchdog two edges late because of the resynchroniser. For that reason the watchdog and pulse-length checks use windows of a few cycles instead of an exact edge.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
  typedef enum logic [1:0] {ST_CFG, ST_WAIT, ST_PULSE, ST_RUN} pgr_state_e;
  localparam int MAX_CODE = 16;
endpackage

// File: rtl/pgr_tick_timer.sv
module pgr_tick_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         reached
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (tick && cnt != {W{1'b1}})
      cnt <= cnt + 1'b1;
  end

  assign reached = (cnt >= limit);

  // once reached with an unchanged limit, the count never falls back (R9 saturation)
  assert_reached_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (reached && !clr) |=> (reached || !$stable(limit)));
endmodule

// File: rtl/pgr_qualify.sv
module pgr_qualify #(
  parameter int N_RAILS = 4,
  parameter int N_GPI   = 2
) (
  input  logic [N_RAILS-1:0] pg_on,
  input  logic [N_RAILS-1:0] pg_fail,
  input  logic [N_RAILS-1:0] rail_mask,
  input  logic [N_GPI-1:0]   gpi,
  input  logic [N_GPI-1:0]   gpi_mask,
  output logic               all_good,
  output logic               any_fail
);
  logic [N_RAILS-1:0] rail_ok;
  logic [N_GPI-1:0]   gpi_ok;

  for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
    assign rail_ok[i] = pg_on[i] | ~rail_mask[i];
  end
  for (genvar j = 0; j < N_GPI; j++) begin : g_gpi
    assign gpi_ok[j] = gpi[j] | ~gpi_mask[j];
  end

  assign all_good = (&rail_ok) & (&gpi_ok);
  assign any_fail = (|(pg_fail & rail_mask)) | (|(~gpi & gpi_mask));
endmodule

// File: rtl/pgr_watchdog.sv
module pgr_watchdog #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic         wdi,
  input  logic [W-1:0] start_lim,
  input  logic [W-1:0] period_lim,
  output logic         timeout
);
  logic [2:0]   sync_q;
  logic         first_q;
  logic         kick;
  logic         reached;
  logic [W-1:0] lim;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], wdi};
  end
  assign kick = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk) begin
    if (rst || !en) first_q <= 1'b1;
    else if (kick)  first_q <= 1'b0;
  end

  assign lim = first_q ? start_lim : period_lim;

  pgr_tick_timer #(.W(W)) u_wd_timer (
    .clk(clk), .rst(rst), .clr(!en || kick), .tick(tick),
    .limit(lim), .reached(reached)
  );

  assign timeout = en && reached;

  assert_kick_defers_R5: assert property (@(posedge clk) disable iff (rst)
    (en && kick && period_lim != '0) |=> !timeout);
endmodule

// File: rtl/pg_reset_gen.sv
module pg_reset_gen
  import pgr_pkg::*;
#(
  parameter int N_RAILS = 4,
  parameter int N_GPI   = 2,
  parameter int TIMER_W = 16,
  parameter int CODE_W  = 5,
  parameter int PW_W    = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_ms,
  input  logic [N_RAILS-1:0] rail_pg_on,
  input  logic [N_RAILS-1:0] rail_pg_fail,
  input  logic [N_RAILS-1:0] rail_mask,
  input  logic [N_GPI-1:0]   gpi_in,
  input  logic [N_GPI-1:0]   gpi_mask,
  input  logic [CODE_W-1:0]  delay_code,
  input  logic               pulse_mode,
  input  logic [PW_W-1:0]    pulse_width,
  input  logic               wdg_en,
  input  logic [TIMER_W-1:0] wdg_start,
  input  logic [TIMER_W-1:0] wdg_period,
  input  logic               wdi,
  input  logic               cfg_write,
  output logic               sys_rst_n
);
  localparam logic [TIMER_W-1:0] ONE = {{(TIMER_W-1){1'b0}}, 1'b1};

  pgr_state_e   st, nxt;
  logic         good, fail, seq_done, wd_timeout, wd_en, seq_clr;
  logic [TIMER_W-1:0] dly_ticks, pw_ticks, seq_limit;

  function automatic logic [TIMER_W-1:0] code_ticks(input logic [CODE_W-1:0] c);
    int unsigned k;
    k = (int'(c) > MAX_CODE) ? MAX_CODE : int'(c);
    if (k == 0) return '0;
    return ONE << (k - 1);
  endfunction

  assign dly_ticks = code_ticks(delay_code);
  assign pw_ticks  = (pulse_width == '0) ? ONE : TIMER_W'(pulse_width);
  assign seq_limit = (st == ST_PULSE) ? pw_ticks : dly_ticks;

  pgr_qualify #(.N_RAILS(N_RAILS), .N_GPI(N_GPI)) u_qual (
    .pg_on(rail_pg_on), .pg_fail(rail_pg_fail), .rail_mask(rail_mask),
    .gpi(gpi_in), .gpi_mask(gpi_mask), .all_good(good), .any_fail(fail)
  );

  always_comb begin
    nxt = st;
    unique case (st)
      ST_CFG:   nxt = ST_WAIT;
      ST_WAIT:  if (good && seq_done) nxt = pulse_mode ? ST_PULSE : ST_RUN;
      ST_PULSE: if (seq_done) nxt = ST_RUN;
      ST_RUN:   if (fail || wd_timeout) nxt = ST_WAIT;
      default:  nxt = ST_CFG;
    endcase
    if (cfg_write) nxt = ST_CFG;
  end

  assign seq_clr = cfg_write || (nxt != st) || (st == ST_WAIT && !good);

  pgr_tick_timer #(.W(TIMER_W)) u_seq_timer (
    .clk(clk), .rst(rst), .clr(seq_clr), .tick(tick_ms),
    .limit(seq_limit), .reached(seq_done)
  );

  assign wd_en = wdg_en && (st == ST_RUN) && !cfg_write;

  pgr_watchdog #(.W(TIMER_W)) u_wdog (
    .clk(clk), .rst(rst), .en(wd_en), .tick(tick_ms), .wdi(wdi),
    .start_lim(wdg_start), .period_lim(wdg_period), .timeout(wd_timeout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_CFG;
      sys_rst_n <= 1'b0;
    end else begin
      st        <= nxt;
      sys_rst_n <= !((nxt == ST_CFG) || (nxt == ST_PULSE) ||
                     (nxt == ST_WAIT && !pulse_mode));
    end
  end

  assert_cfg_asserts_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_write |=> !sys_rst_n);

  assert_level_fail_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && !pulse_mode && fail) |=> !sys_rst_n);

  assert_hold_until_good_R1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && !pulse_mode && !good) |=> !sys_rst_n);

  assert_wd_timeout_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && !pulse_mode && wd_timeout) |=> !sys_rst_n);
endmodule

// File: tb/test_pg_reset_gen.sv
module test_pg_reset_gen;
  logic clk = 0, rst = 1, tick_ms = 1;
  logic [3:0] rail_pg_on = '1, rail_pg_fail = '0, rail_mask = '1;
  logic [1:0] gpi_in = '1, gpi_mask = '1;
  logic [4:0] delay_code = '0;
  logic pulse_mode = 0, wdg_en = 0, wdi = 0, cfg_write = 0;
  logic [14:0] pulse_width = 15'd1;
  logic [15:0] wdg_start = 16'd60, wdg_period = 16'd25;
  logic sys_rst_n;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pg_reset_gen i_pg_reset_gen (.*);

  function automatic int exp_delay(input int code);
    if (code == 0) return 0;
    if (code > 16) code = 16;
    return 1 << (code - 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // pulse cfg_write; returns at the negedge after the strobe edge
  task automatic do_cfg();
    cfg_write = 1;
    @(negedge clk);
    cfg_write = 0;
    chk(!sys_rst_n, "R7 cfg write asserts", sys_rst_n, 0);
  endtask

  task automatic wait_level(input logic lvl, input int lim, output int k);
    k = 0;
    while (sys_rst_n !== lvl && k < lim) begin
      @(negedge clk);
      k++;
    end
  endtask

  int k, d, pw, low_len, idx;
  logic stayed;

  initial begin
    void'($urandom(32'd4242));
    step(3);
    chk(!sys_rst_n, "R7 reset state", sys_rst_n, 0);
    rst = 0;
    step(1);

    // R1/R2/R3 random sweep
    for (int it = 0; it < 12; it++) begin
      rail_mask  = 4'($urandom);
      gpi_mask   = 2'($urandom);
      rail_pg_on = rail_mask | 4'($urandom);
      gpi_in     = gpi_mask | 2'($urandom);
      delay_code = 5'($urandom % 8);
      d = exp_delay(delay_code);
      do_cfg();
      wait_level(1'b1, 500, k);
      chk(sys_rst_n && k >= d + 1 && k <= d + 3, "R2 R1 release latency", k, d + 2);
      idx = $urandom % 4;
      rail_pg_fail[idx] = 1'b1;
      step(1);
      if (rail_mask[idx]) begin
        chk(!sys_rst_n, "R3 selected fail asserts", sys_rst_n, 0);
      end else begin
        step(4);
        chk(sys_rst_n, "R3 deselected fail ignored", sys_rst_n, 1);
      end
      rail_pg_fail = '0;
    end

    // R1: selected rail not good holds reset
    rail_mask = 4'b0011; gpi_mask = 2'b01; gpi_in = 2'b01;
    rail_pg_on = 4'b0001; delay_code = 0;
    do_cfg();
    step(40);
    chk(!sys_rst_n, "R1 selected rail low holds", sys_rst_n, 0);
    rail_pg_on = 4'b0011;
    wait_level(1'b1, 10, k);
    chk(sys_rst_n === 1'b1, "R1 release when good", sys_rst_n, 1);
    // R3 selected gpi low
    gpi_in = 2'b00;
    step(1);
    chk(!sys_rst_n, "R3 selected gpi low asserts", sys_rst_n, 0);
    gpi_in = 2'b01;

    // R7: cfg while all good still asserts
    step(3);
    do_cfg();
    wait_level(1'b1, 10, k);
    chk(sys_rst_n === 1'b1, "R7 re-evaluated after cfg", sys_rst_n, 1);

    // R2: largest code
    delay_code = 5'd16;
    do_cfg();
    wait_level(1'b1, 40000, k);
    chk(k >= 32769 && k <= 32771, "R2 code16 latency", k, 32770);

    // R8: failure during delay restarts count
    delay_code = 5'd6;
    do_cfg();
    step(15);
    gpi_in = 2'b00;
    step(1);
    gpi_in = 2'b01;
    wait_level(1'b1, 200, k);
    chk(k >= 32 && k <= 35, "R8 count restarted", k, 33);

    // R9: no tick, no progress
    delay_code = 5'd4;
    tick_ms = 0;
    do_cfg();
    step(50);
    chk(!sys_rst_n, "R9 held without tick", sys_rst_n, 0);
    tick_ms = 1;
    wait_level(1'b1, 100, k);
    chk(k >= 8 && k <= 11, "R9 counts after tick", k, 9);

    // R4: pulse mode
    for (int it = 0; it < 4; it++) begin
      pulse_mode = 1;
      pw = (it == 0) ? 0 : 1 + ($urandom % 20);
      pulse_width = 15'(pw);
      delay_code = 5'd1;
      do_cfg();
      step(1);
      chk(sys_rst_n, "R4 high while waiting", sys_rst_n, 1);
      wait_level(1'b0, 20, k);
      wait_level(1'b1, 100, low_len);
      if (pw == 0) pw = 1;
      chk(low_len >= pw && low_len <= pw + 2, "R4 pulse width", low_len, pw + 1);
    end

    // R10: loss of power after pulse re-arms without asserting
    step(3);
    rail_pg_on[0] = 0; rail_pg_fail[0] = 1;
    stayed = 1;
    for (int i = 0; i < 6; i++) begin
      step(1);
      if (!sys_rst_n) stayed = 0;
    end
    chk(stayed, "R10 no assert on fail in pulse mode", stayed, 1);
    rail_pg_on[0] = 1; rail_pg_fail[0] = 0;
    wait_level(1'b0, 20, k);
    chk(!sys_rst_n, "R10 new pulse after recovery", sys_rst_n, 0);
    wait_level(1'b1, 100, k);

    // R5/R6: watchdog in level mode
    pulse_mode = 0; delay_code = 5'd2; wdg_en = 1;
    do_cfg();
    wait_level(1'b1, 20, k);
    step(40);
    chk(sys_rst_n, "R5 no timeout inside start time", sys_rst_n, 1);
    wdi = 1; step(2); wdi = 0;
    step(13);
    chk(sys_rst_n, "R5 kick restarts window", sys_rst_n, 1);
    wait_level(1'b0, 40, k);
    chk(!sys_rst_n && k >= 9 && k <= 19, "R5 period timeout after kick", k, 14);
    wait_level(1'b1, 20, k);
    chk(sys_rst_n && k >= 2 && k <= 5, "R6 release after delay", k, 3);
    wait_level(1'b0, 100, k);
    chk(!sys_rst_n && k >= 58 && k <= 64, "R6 start-time timeout", k, 61);
    wdg_en = 0;
    do_cfg();
    wait_level(1'b1, 20, k);
    step(150);
    chk(sys_rst_n, "R5 disabled watchdog idle", sys_rst_n, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 190000);
    errors++; checks++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule